// File: doc/BRIEF.md
# Multiplexed Asynchronous Bus Master

This block lets a local agent run single read and write cycles on an asynchronous system bus whose address and data share one set of wires. The agent presents a 22-bit byte address, a direction, a byte-or-word size and, for writes, 16 bits of data. The block then runs an address phase on the shared lines, followed by a data phase. Completion depends on a request/acknowledge exchange with the one answering slave, so a slow slave simply stretches the cycle.

The block raises a dedicated select line while it drives an address that falls in the top 8 KB, the I/O page. Byte transfers use address bit 0 to choose the byte lane. The slave's reply is brought into the local clock domain through a flip-flop synchronizer. A counter in the master ends any cycle that no slave finishes in time and reports it as a bus error on the local side.

Top module: `mux_bus_master`

## Requirements
- R1: After reset, reqReady is 1 and busSync, busDin, busDout, busAdOe, busIoSel, busByte, rspDone and rspErr are all 0.
- R2: An accepted request starts with a one-cycle address phase. During it busAdOe is 1, busSync is 1 and busAdOut carries the address, with bit 0 forced to 0 for word accesses. busSync then stays at 1 until the cycle ends.
- R3: busIoSel is 1 during the address phase exactly when address bits 21:13 are all ones. At every other time it is 0.
- R4: On a read, busAdOe is 0 while busDin is 1. For a word read, rspRdata takes busAdIn[15:0] as it was when the synchronized reply was seen. A successful cycle ends with rspDone high for exactly one cycle.
- R5: On a byte read, rspRdata is {8'h00, busAdIn[7:0]} for an even address and {8'h00, busAdIn[15:8]} for an odd address.
- R6: On a write, the data is on busAdOut[15:0] with busAdOe at 1 before busDout rises and while it is high. A word write carries the whole word. A byte write to an even address carries {8'h00, wdata[7:0]}, and one to an odd address carries {wdata[7:0], 8'h00}. busByte is 1 during the data phase of byte writes and 0 for word writes.
- R7: The data strobe (busDin or busDout) stays high until the synchronized reply is seen, so each extra cycle of slave delay lengthens the transfer by exactly one cycle. busDin and busDout are never high together.
- R8: Once the reply is seen, the strobe drops. busSync stays high until the reply has been released, and then the cycle ends with busSync at 0.
- R9: If the reply does not arrive within TIMEOUT_CYCLES cycles of strobe assertion, the cycle is abandoned. rspErr pulses for one cycle, rspDone stays 0, all bus outputs drop and the block is idle again. With the strobe first high in cycle 3 after acceptance, rspErr is seen in cycle TIMEOUT_CYCLES+3.
- R10: A reply that is seen on the same clock edge at which the timeout would expire counts as success: the cycle completes with rspDone and no rspErr.
- R11: reqReady is 0 from acceptance until the cycle ends. A reqValid presented while busy is ignored and does not start a further cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle; request taken when both high |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqByte | input | 1 | 1 = byte transfer, 0 = word |
| reqAddr | input | 22 | Byte address |
| reqWdata | input | 16 | Write data (byte writes use bits 7:0) |
| rspDone | output | 1 | One-cycle pulse on successful completion |
| rspErr | output | 1 | One-cycle pulse on timeout |
| rspRdata | output | 16 | Read data, valid from rspDone onward |
| busAdOut | output | 22 | Shared lines, driven value |
| busAdOe | output | 1 | Shared lines output enable |
| busAdIn | input | 16 | Shared lines, received value |
| busSync | output | 1 | Cycle-framing strobe |
| busDin | output | 1 | Read data strobe |
| busDout | output | 1 | Write data strobe |
| busByte | output | 1 | Byte-mode indication in data phase |
| busIoSel | output | 1 | I/O page select in address phase |
| busReply | input | 1 | Slave reply, asynchronous |

## Verification
A slave reply and the expiry of the timeout counter can land on the same clock edge. The two outcomes are opposite: one completes the cycle, the other aborts it. The bench drives this case by setting its slave model's reply delay so that the synchronized reply arrives exactly on the expiry edge. It then expects rspDone without rspErr. Moving the reply one cycle later must give rspErr without rspDone, which pins down the boundary from both sides.

// File: rtl/mbm_pkg.sv
package mbm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SETUP,
    ST_STROBE,
    ST_RELEASE
  } busState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;    // latch the local request
    logic driveAddr;  // address phase on shared lines
    logic driveData;  // write data on shared lines
    logic dataPhase;  // data phase in progress
    logic captureRd;  // store read data from the lines
  } dpCtrl_t;

endpackage

// File: rtl/mbm_sync.sv
module mbm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] stageQ;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[0] <= 1'b0;
          else       stageQ[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[i] <= 1'b0;
          else       stageQ[i] <= stageQ[i-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/mbm_datapath.sv
module mbm_datapath
  import mbm_pkg::*;
#(
  parameter int ADDR_W       = 22,
  parameter int DATA_W       = 16,
  parameter int IO_BANK_BITS = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic              reqWrite,
  input  logic              reqByte,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busAdIn,
  output logic              isWrite,
  output logic [ADDR_W-1:0] busAdOut,
  output logic              busAdOe,
  output logic              busIoSel,
  output logic              busByte,
  output logic [DATA_W-1:0] rdData
);

  localparam int LANE_W = DATA_W / 2;
  localparam int PAD_W  = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic              writeQ;
  logic              byteQ;
  logic [DATA_W-1:0] rdQ;
  logic [ADDR_W-1:0] addrOnBus;
  logic [DATA_W-1:0] wLane;
  logic [DATA_W-1:0] rdNext;
  logic              ioPage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      writeQ <= 1'b0;
      byteQ  <= 1'b0;
    end else if (ctrl.loadReq) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      writeQ <= reqWrite;
      byteQ  <= reqByte;
    end
  end

  // word accesses always go out on an even byte address
  assign addrOnBus = byteQ ? addrQ : {addrQ[ADDR_W-1:1], 1'b0};
  assign ioPage    = &addrQ[ADDR_W-1 -: IO_BANK_BITS];

  // byte lane steering for writes
  always_comb begin
    case ({byteQ, addrQ[0]})
      2'b10:   wLane = {{LANE_W{1'b0}}, wdataQ[LANE_W-1:0]};
      2'b11:   wLane = {wdataQ[LANE_W-1:0], {LANE_W{1'b0}}};
      default: wLane = wdataQ;
    endcase
  end

  // byte lane selection for reads
  always_comb begin
    case ({byteQ, addrQ[0]})
      2'b10:   rdNext = {{LANE_W{1'b0}}, busAdIn[LANE_W-1:0]};
      2'b11:   rdNext = {{LANE_W{1'b0}}, busAdIn[DATA_W-1:LANE_W]};
      default: rdNext = busAdIn;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rdQ <= '0;
    else if (ctrl.captureRd) rdQ <= rdNext;
  end

  always_comb begin
    if (ctrl.driveAddr)      busAdOut = addrOnBus;
    else if (ctrl.driveData) busAdOut = {{PAD_W{1'b0}}, wLane};
    else                     busAdOut = '0;
  end

  assign busAdOe  = ctrl.driveAddr | ctrl.driveData;
  assign busIoSel = ctrl.driveAddr & ioPage;
  assign busByte  = ctrl.dataPhase & byteQ & writeQ;
  assign isWrite  = writeQ;
  assign rdData   = rdQ;

  AST_IOSEL_IN_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    busIoSel |-> (busAdOe && !ctrl.dataPhase)) else $error("ioSel outside address phase"); // R3

  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.captureRd |=> $stable(rdData)) else $error("read data changed without capture"); // R4

  AST_BYTE_NO_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    busByte |-> !ctrl.driveAddr) else $error("byte mode during address phase"); // R6

endmodule

// File: rtl/mbm_ctrl.sv
module mbm_ctrl
  import mbm_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 1024
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    isWrite,
  input  logic    replySync,
  output logic    reqReady,
  output logic    busSync,
  output logic    busDin,
  output logic    busDout,
  output logic    rspDone,
  output logic    rspErr,
  output dpCtrl_t dpCtrl
);

  localparam int TIMER_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [TIMER_W-1:0] TIMER_LAST = TIMER_W'(TIMEOUT_CYCLES - 1);

  busState_t         state, stateNext;
  logic [TIMER_W-1:0] timer, timerNext;
  logic              doneNext, errNext;
  logic              timeoutHit;
  logic              strobeOn;

  assign timeoutHit = (timer == TIMER_LAST);

  always_comb begin
    stateNext = state;
    timerNext = '0;
    doneNext  = 1'b0;
    errNext   = 1'b0;
    case (state)
      ST_IDLE:  if (reqValid) stateNext = ST_ADDR;
      ST_ADDR:  stateNext = ST_SETUP;
      ST_SETUP: stateNext = ST_STROBE;
      ST_STROBE: begin
        if (replySync) begin
          stateNext = ST_RELEASE;          // reply wins over expiry
        end else if (timeoutHit) begin
          stateNext = ST_IDLE;
          errNext   = 1'b1;
        end else begin
          timerNext = timer + 1'b1;
        end
      end
      ST_RELEASE: begin
        if (!replySync) begin
          stateNext = ST_IDLE;
          doneNext  = 1'b1;
        end else if (timeoutHit) begin
          stateNext = ST_IDLE;
          errNext   = 1'b1;
        end else begin
          timerNext = timer + 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      timer   <= '0;
      rspDone <= 1'b0;
      rspErr  <= 1'b0;
    end else begin
      state   <= stateNext;
      timer   <= timerNext;
      rspDone <= doneNext;
      rspErr  <= errNext;
    end
  end

  assign strobeOn = (state == ST_STROBE);
  assign reqReady = (state == ST_IDLE);
  assign busSync  = (state != ST_IDLE);
  assign busDin   = strobeOn & ~isWrite;
  assign busDout  = strobeOn & isWrite;

  always_comb begin
    dpCtrl.loadReq   = (state == ST_IDLE) & reqValid;
    dpCtrl.driveAddr = (state == ST_ADDR);
    dpCtrl.dataPhase = (state == ST_SETUP) | (state == ST_STROBE) | (state == ST_RELEASE);
    dpCtrl.driveData = dpCtrl.dataPhase & isWrite;
    dpCtrl.captureRd = strobeOn & replySync & ~isWrite;
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(busDin && busDout)) else $error("both strobes high"); // R7

  AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ((busDin || busDout) && !replySync && !timeoutHit) |=> (busDin || busDout))
    else $error("strobe dropped before reply"); // R7

  AST_STROBE_IN_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    (busDin || busDout) |-> busSync) else $error("strobe outside sync"); // R8

  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(rspDone && rspErr)) else $error("done and error together"); // R9

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    timer <= TIMER_LAST) else $error("timer overflow"); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone) else $error("done longer than one cycle"); // R4

  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (reqReady && !busSync)) else $error("error without return to idle"); // R9

endmodule

// File: rtl/mux_bus_master.sv
module mux_bus_master
  import mbm_pkg::*;
#(
  parameter int ADDR_W         = 22,
  parameter int DATA_W         = 16,
  parameter int IO_BANK_BITS   = 9,
  parameter int TIMEOUT_CYCLES = 1024,
  parameter int SYNC_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic              reqByte,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspDone,
  output logic              rspErr,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] busAdOut,
  output logic              busAdOe,
  input  logic [DATA_W-1:0] busAdIn,
  output logic              busSync,
  output logic              busDin,
  output logic              busDout,
  output logic              busByte,
  output logic              busIoSel,
  input  logic              busReply
);

  dpCtrl_t dpCtrl;
  logic    replySync;
  logic    isWrite;

  mbm_sync #(.STAGES(SYNC_STAGES)) i_replySync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (busReply),
    .syncOut (replySync)
  );

  mbm_ctrl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .isWrite   (isWrite),
    .replySync (replySync),
    .reqReady  (reqReady),
    .busSync   (busSync),
    .busDin    (busDin),
    .busDout   (busDout),
    .rspDone   (rspDone),
    .rspErr    (rspErr),
    .dpCtrl    (dpCtrl)
  );

  mbm_datapath #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .IO_BANK_BITS (IO_BANK_BITS)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (dpCtrl),
    .reqWrite (reqWrite),
    .reqByte  (reqByte),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .busAdIn  (busAdIn),
    .isWrite  (isWrite),
    .busAdOut (busAdOut),
    .busAdOe  (busAdOe),
    .busIoSel (busIoSel),
    .busByte  (busByte),
    .rdData   (rspRdata)
  );

endmodule

// File: tb/test_mux_bus_master.sv
module test_mux_bus_master;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic        reqByte = 1'b0;
  logic [21:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic        rspDone, rspErr;
  logic [15:0] rspRdata;
  logic [21:0] busAdOut;
  logic        busAdOe;
  logic [15:0] busAdIn;
  logic        busSync, busDin, busDout, busByte, busIoSel;
  logic        busReply;

  int checks = 0;
  int fails  = 0;

  // slave model state
  bit          slaveEn = 1'b1;
  int          slaveDelay = 1;
  logic [15:0] slaveRdata = 16'h0000;
  logic        replyReg = 1'b0;
  int          cnt = 0;
  logic        prevSync = 1'b0;
  logic [21:0] addrSeen = '0;
  logic        ioSeen = 1'b0;
  logic        oeAtAddr = 1'b0;
  logic [15:0] wrSeen = '0;
  logic        byteSeen = 1'b0;
  logic        oeAtWr = 1'b0;
  logic        oeDuringDin = 1'b0;
  logic        syncDropWithReply = 1'b0;

  assign busReply = replyReg;
  assign busAdIn  = slaveRdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_bus_master #(.TIMEOUT_CYCLES(LIMIT)) i_mux_bus_master (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqByte(reqByte), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspDone(rspDone), .rspErr(rspErr), .rspRdata(rspRdata),
    .busAdOut(busAdOut), .busAdOe(busAdOe), .busAdIn(busAdIn),
    .busSync(busSync), .busDin(busDin), .busDout(busDout), .busByte(busByte),
    .busIoSel(busIoSel), .busReply(busReply)
  );

  // slave model, acts between clock edges
  always @(negedge clk) begin
    if (busSync && !prevSync) begin
      addrSeen <= busAdOut;
      ioSeen   <= busIoSel;
      oeAtAddr <= busAdOe;
    end
    prevSync <= busSync;
    if (busDin && busAdOe) oeDuringDin <= 1'b1;
    if (replyReg && !busSync) syncDropWithReply <= 1'b1;
    if (busDin || busDout) begin
      if (!replyReg) begin
        if (slaveEn && (cnt + 1 == slaveDelay)) begin
          replyReg <= 1'b1;
          if (busDout) begin
            wrSeen   <= busAdOut[15:0];
            byteSeen <= busByte;
            oeAtWr   <= busAdOe;
          end
        end
        cnt <= cnt + 1;
      end
    end else begin
      replyReg <= 1'b0;
      cnt      <= 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic w, input logic b, input logic [21:0] a,
                      input logic [15:0] wd, input int d, input bit pokeBusy,
                      output logic gotDone, output logic gotErr, output int cyc,
                      output logic readyLow);
    @(negedge clk);
    slaveDelay = d;
    oeDuringDin = 1'b0;
    syncDropWithReply = 1'b0;
    reqWrite = w; reqByte = b; reqAddr = a; reqWdata = wd; reqValid = 1'b1;
    gotDone = 1'b0; gotErr = 1'b0; cyc = 0; readyLow = 1'b0;
    @(posedge clk);
    while (cyc < 200) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) begin
        reqValid = 1'b0;
        readyLow = !reqReady;
      end
      if (pokeBusy && cyc == 4) reqValid = 1'b1;
      if (pokeBusy && cyc == 5) reqValid = 1'b0;
      if (rspDone || rspErr) begin
        gotDone = rspDone;
        gotErr  = rspErr;
        break;
      end
    end
  endtask

  task automatic idleWait(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R1 reqReady", reqReady, 1);
    chk("R1 sync/strobes", {busSync, busDin, busDout}, 0);
    chk("R1 oe/iosel/byte", {busAdOe, busIoSel, busByte}, 0);
    chk("R1 done/err", {rspDone, rspErr}, 0);
  endtask

  task automatic testWordRead();
    logic dn, er, rl; int c;
    slaveRdata = 16'hBEEF;
    xfer(1'b0, 1'b0, 22'h001234, 16'h0, 3, 1'b0, dn, er, c, rl);
    chk("R4 done", {dn, er}, 2'b10);
    chk("R4 rdata", rspRdata, 16'hBEEF);
    chk("R4 lines released", oeDuringDin, 0);
    chk("R2 address", addrSeen, 22'h001234);
    chk("R2 oe in address phase", oeAtAddr, 1);
    chk("R3 no iosel", ioSeen, 0);
    chk("R8 sync held with reply", syncDropWithReply, 0);
    @(negedge clk);
    chk("R4 done one cycle", rspDone, 0);
    chk("R8 sync low after end", busSync, 0);
    xfer(1'b0, 1'b0, 22'h000101, 16'h0, 2, 1'b0, dn, er, c, rl);
    chk("R2 word address even", addrSeen, 22'h000100);
    idleWait(3);
  endtask

  task automatic testByteRead();
    logic dn, er, rl; int c;
    slaveRdata = 16'hA55A;
    xfer(1'b0, 1'b1, 22'h000200, 16'h0, 2, 1'b0, dn, er, c, rl);
    chk("R5 even lane", rspRdata, 16'h005A);
    xfer(1'b0, 1'b1, 22'h000201, 16'h0, 2, 1'b0, dn, er, c, rl);
    chk("R5 odd lane", rspRdata, 16'h00A5);
    chk("R2 byte address kept odd", addrSeen, 22'h000201);
    idleWait(3);
  endtask

  task automatic testWrites();
    logic dn, er, rl; int c;
    xfer(1'b1, 1'b0, 22'h000300, 16'h1357, 2, 1'b0, dn, er, c, rl);
    chk("R6 word data", wrSeen, 16'h1357);
    chk("R6 word no byte flag", byteSeen, 0);
    chk("R6 oe during write", oeAtWr, 1);
    chk("R6 word done", {dn, er}, 2'b10);
    xfer(1'b1, 1'b1, 22'h000302, 16'hFF77, 2, 1'b0, dn, er, c, rl);
    chk("R6 byte even lane", wrSeen, 16'h0077);
    chk("R6 byte flag", byteSeen, 1);
    xfer(1'b1, 1'b1, 22'h000303, 16'hFF77, 1, 1'b0, dn, er, c, rl);
    chk("R6 byte odd lane", wrSeen, 16'h7700);
    idleWait(3);
  endtask

  task automatic testIoPage();
    logic dn, er, rl; int c;
    xfer(1'b0, 1'b0, 22'h3FE000, 16'h0, 2, 1'b0, dn, er, c, rl);
    chk("R3 io page low edge", ioSeen, 1);
    xfer(1'b1, 1'b0, 22'h3FDFFE, 16'h0, 2, 1'b0, dn, er, c, rl);
    chk("R3 just below io page", ioSeen, 0);
    xfer(1'b0, 1'b1, 22'h3FFFFF, 16'h0, 2, 1'b0, dn, er, c, rl);
    chk("R3 io page top", ioSeen, 1);
    @(negedge clk);
    chk("R3 iosel low when idle", busIoSel, 0);
    idleWait(3);
  endtask

  task automatic testStretch();
    logic dn, er, rl; int c1, c2;
    xfer(1'b0, 1'b0, 22'h000010, 16'h0, 1, 1'b0, dn, er, c1, rl);
    xfer(1'b0, 1'b0, 22'h000010, 16'h0, 9, 1'b0, dn, er, c2, rl);
    chk("R7 stretched done", dn, 1);
    chk("R7 delay adds cycles", c2 - c1, 8);
    idleWait(3);
  endtask

  task automatic testTimeout();
    logic dn, er, rl; int c;
    slaveEn = 1'b0;
    xfer(1'b0, 1'b0, 22'h000020, 16'h0, 1, 1'b0, dn, er, c, rl);
    slaveEn = 1'b1;
    chk("R9 error no done", {dn, er}, 2'b01);
    chk("R9 expiry cycle", c, LIMIT + 3);
    chk("R9 idle after error", {reqReady, busSync, busDin}, 3'b100);
    @(negedge clk);
    chk("R9 error one cycle", rspErr, 0);
    idleWait(4);
  endtask

  task automatic testRace();
    logic dn, er, rl; int c;
    xfer(1'b0, 1'b0, 22'h000030, 16'h0, LIMIT - 2, 1'b0, dn, er, c, rl);
    chk("R10 reply on expiry edge wins", {dn, er}, 2'b10);
    idleWait(4);
    xfer(1'b0, 1'b0, 22'h000030, 16'h0, LIMIT - 1, 1'b0, dn, er, c, rl);
    chk("R10 one cycle later times out", {dn, er}, 2'b01);
    idleWait(5);
  endtask

  task automatic testBusyIgnore();
    logic dn, er, rl; int c;
    xfer(1'b0, 1'b0, 22'h000040, 16'h0, 3, 1'b1, dn, er, c, rl);
    chk("R11 ready low while busy", rl, 1);
    chk("R11 cycle completes", dn, 1);
    idleWait(3);
    chk("R11 no extra cycle", busSync, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    idleWait(2);
    testWordRead();
    testByteRead();
    testWrites();
    testIoPage();
    testStretch();
    testTimeout();
    testRace();
    testBusyIgnore();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule